// File: doc/BRIEF.md
# Fan Control Command Handler

This block sits on a byte-wide command channel and serves the fan-control command (code 0x4A). It holds one setpoint register per fan for a bank of six RPM-regulated fans and a bank of six PWM-driven fans, and it reports either these setpoints or the measured speeds that the surrounding logic supplies. How many argument bytes follow the command code decides what the frame means. A single argument byte asks for a report. Fourteen argument bytes write new setpoints into the fans that a mask selects.

Commands come in on a valid/ready byte stream. A start marker flags the command-code byte and an end marker flags the final byte of the frame. Replies go out on a second valid/ready byte stream whose final byte carries a last flag. The handler works on one frame at a time. After it accepts the end byte of a frame it holds `in_ready` low, and it raises `in_ready` again only once the last reply byte has been taken. The reply stream obeys back-pressure: while `out_ready` is low, the byte on offer stays unchanged. Words are 16 bits wide and travel most-significant byte first in both directions.

Top module: `fan_cmd_handler`

## Requirements
- R1: A frame whose first byte is not 0x4A gets a one-byte reply of 0xFF and leaves every setpoint unchanged, whatever its length or contents.
- R2: A query reply has 13 bytes. Byte 0 is the configured active-fan mask of the chosen bank, with bit n standing for fan n and bits 7:6 reading zero. Bytes 1..12 follow as fan 0 to fan 5, each word high byte first. `out_last` is set only on byte 12.
- R3: The single query argument picks the reply source: 0x01 returns the RPM measured speeds, 0x02 the RPM setpoints, 0x11 the PWM measured speeds and 0x12 the PWM setpoints.
- R4: A frame with 14 argument bytes is a setpoint write. Argument 0 selects the bank (0x00 RPM, 0x10 PWM), argument 1 is the fan mask (bit n = fan n), and arguments 2..13 carry six words for fan 0 to fan 5, high byte first. Each selected fan takes its word, and the reply is the single byte 0x00.
- R5: A fan whose mask bit is clear keeps its setpoint even when its word is nonzero. Mask bits 7:6 have no effect.
- R6: Any argument count other than 1 or 14, an unknown query byte, or an unknown bank byte gets the single reply byte 0xFF and changes no setpoint.
- R7: After reset every setpoint is zero, `out_valid` is low and `in_ready` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values. From the accepted end byte until the last reply byte is taken, `in_ready` stays low.
- R9: A byte taken while no frame is open and without the start marker is dropped with no reply. A start marker in the middle of a frame throws the partial frame away and opens a new one.
- R10: Each complete frame produces exactly one reply. Its final byte carries `out_last`, and a non-query reply is one byte long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Handler can accept a command byte |
| in_data | input | 8 | Command byte |
| in_sof | input | 1 | Byte is the command code that opens a frame |
| in_eof | input | 1 | Byte closes the frame |
| out_valid | output | 1 | Reply byte valid |
| out_ready | input | 1 | Consumer takes the reply byte |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Final byte of the reply |
| rpm_present | input | 6 | Active-fan mask reported for the RPM bank |
| pwm_present | input | 6 | Active-fan mask reported for the PWM bank |
| rpm_meas | input | 96 | Measured RPM fan speeds, fan n in bits 16n+15:16n |
| pwm_meas | input | 96 | Measured PWM fan speeds, same packing |
| rpm_setpt | output | 96 | RPM bank setpoint registers, same packing |
| pwm_setpt | output | 96 | PWM bank setpoint registers, same packing |

## Verification
The assertions run on every cycle and cover the reply handshake. They check that the offered byte stays stable under back-pressure and that input is blocked while a reply is pending. They also check that a setpoint register changes only in the cycle a one-byte 0x00 acknowledge appears, and that the last flag comes only with valid data. The directed scenarios are the only place the content is checked: the byte order of query replies, the choice of source for each selector, the masking of individual fans, and the refusal of bad frames with registers left as they were. The scenarios also cover stray-byte dropping and restarting a frame partway through.

// File: rtl/fan_cmd_pkg.sv
package fan_cmd_pkg;
  localparam logic [7:0] FAN_CMD_CODE = 8'h4A;
  localparam logic [7:0] SEL_RPM_MEAS = 8'h01;
  localparam logic [7:0] SEL_RPM_SETP = 8'h02;
  localparam logic [7:0] SEL_PWM_MEAS = 8'h11;
  localparam logic [7:0] SEL_PWM_SETP = 8'h12;
  localparam logic [7:0] BANK_RPM     = 8'h00;
  localparam logic [7:0] BANK_PWM     = 8'h10;
  localparam logic [7:0] REPLY_ERR    = 8'hFF;
  localparam logic [7:0] REPLY_ACK    = 8'h00;
  localparam int         WORD_W       = 16;
  localparam int         WORD_BYTES   = WORD_W / 8;

  typedef enum logic [1:0] {
    REQ_ERR   = 2'd0,
    REQ_QUERY = 2'd1,
    REQ_SET   = 2'd2
  } req_kind_e;
endpackage

// File: rtl/fan_cmd_parser.sv
module fan_cmd_parser
  import fan_cmd_pkg::*;
#(
  parameter int NUM_FANS = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [7:0]                 in_data,
  input  logic                       in_sof,
  input  logic                       in_eof,
  input  logic                       reply_done,
  output logic                       req_valid,
  output req_kind_e                  req_kind,
  output logic                       req_bank,
  output logic                       req_meas,
  output logic [NUM_FANS-1:0]        req_mask,
  output logic [NUM_FANS*WORD_W-1:0] req_words
);
  localparam int DATA_BYTES = NUM_FANS * WORD_BYTES;
  localparam int SET_ARGS   = 2 + DATA_BYTES;
  localparam int CNT_MAX    = SET_ARGS + 1;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {P_IDLE, P_BODY, P_WAIT} pstate_e;

  pstate_e          state_q;
  logic [7:0]       code_q;
  logic [7:0]       arg0_q;
  logic [7:0]       arg1_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       dbuf_q [DATA_BYTES];
  logic             req_valid_q;
  logic             accept;

  assign in_ready = (state_q != P_WAIT);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= P_IDLE;
      code_q      <= '0;
      arg0_q      <= '0;
      arg1_q      <= '0;
      cnt_q       <= '0;
      req_valid_q <= 1'b0;
      for (int i = 0; i < DATA_BYTES; i++) dbuf_q[i] <= '0;
    end else begin
      req_valid_q <= 1'b0;
      case (state_q)
        P_IDLE, P_BODY: begin
          if (accept) begin
            if (in_sof) begin
              code_q <= in_data;
              cnt_q  <= '0;
              if (in_eof) begin
                state_q     <= P_WAIT;
                req_valid_q <= 1'b1;
              end else begin
                state_q <= P_BODY;
              end
            end else if (state_q == P_BODY) begin
              if (cnt_q == CNT_W'(0)) arg0_q <= in_data;
              if (cnt_q == CNT_W'(1)) arg1_q <= in_data;
              for (int i = 0; i < DATA_BYTES; i++) begin
                if (cnt_q == CNT_W'(i + 2)) dbuf_q[i] <= in_data;
              end
              if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + CNT_W'(1);
              if (in_eof) begin
                state_q     <= P_WAIT;
                req_valid_q <= 1'b1;
              end
            end
          end
        end
        P_WAIT: if (reply_done) state_q <= P_IDLE;
        default: state_q <= P_IDLE;
      endcase
    end
  end

  // Decode the captured frame while req_valid is high
  always_comb begin
    req_kind = REQ_ERR;
    req_bank = 1'b0;
    req_meas = 1'b0;
    if (code_q == FAN_CMD_CODE) begin
      if (cnt_q == CNT_W'(1)) begin
        if (arg0_q == SEL_RPM_MEAS || arg0_q == SEL_RPM_SETP ||
            arg0_q == SEL_PWM_MEAS || arg0_q == SEL_PWM_SETP) begin
          req_kind = REQ_QUERY;
          req_bank = arg0_q[4];
          req_meas = (arg0_q[3:0] == 4'h1);
        end
      end else if (cnt_q == CNT_W'(SET_ARGS)) begin
        if (arg0_q == BANK_RPM || arg0_q == BANK_PWM) begin
          req_kind = REQ_SET;
          req_bank = arg0_q[4];
        end
      end
    end
  end

  assign req_valid = req_valid_q;
  assign req_mask  = arg1_q[NUM_FANS-1:0];

  for (genvar g = 0; g < NUM_FANS; g++) begin : g_word
    assign req_words[g*WORD_W +: WORD_W] = {dbuf_q[g*WORD_BYTES], dbuf_q[g*WORD_BYTES+1]};
  end
endmodule

// File: rtl/fan_cmd_bank.sv
module fan_cmd_bank
  import fan_cmd_pkg::*;
#(
  parameter int NUM_FANS = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [NUM_FANS-1:0]        wr_mask,
  input  logic [NUM_FANS*WORD_W-1:0] wr_words,
  output logic [NUM_FANS*WORD_W-1:0] setpt
);
  for (genvar g = 0; g < NUM_FANS; g++) begin : g_fan
    logic [WORD_W-1:0] sp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   sp_q <= '0;
      else if (wr_en && wr_mask[g]) sp_q <= wr_words[g*WORD_W +: WORD_W];
    end
    assign setpt[g*WORD_W +: WORD_W] = sp_q;
  end
endmodule

// File: rtl/fan_cmd_reply.sv
module fan_cmd_reply
  import fan_cmd_pkg::*;
#(
  parameter int NUM_FANS = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  req_kind_e                  load_kind,
  input  logic [7:0]                 load_mask,
  input  logic [NUM_FANS*WORD_W-1:0] load_words,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [7:0]                 out_data,
  output logic                       out_last,
  output logic                       done
);
  localparam int RLEN  = 1 + NUM_FANS * WORD_BYTES;
  localparam int IDX_W = $clog2(RLEN + 1);

  logic [7:0]       sh_q [RLEN];
  logic [IDX_W-1:0] idx_q;
  logic             short_q;
  logic             valid_q;
  logic [IDX_W-1:0] last_idx;
  logic             at_last;

  assign last_idx = short_q ? '0 : IDX_W'(RLEN - 1);
  assign at_last  = (idx_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      short_q <= 1'b1;
      for (int i = 0; i < RLEN; i++) sh_q[i] <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      idx_q   <= '0;
      short_q <= (load_kind != REQ_QUERY);
      case (load_kind)
        REQ_QUERY: sh_q[0] <= load_mask;
        REQ_SET:   sh_q[0] <= REPLY_ACK;
        default:   sh_q[0] <= REPLY_ERR;
      endcase
      for (int i = 0; i < NUM_FANS; i++) begin
        sh_q[1 + i*WORD_BYTES] <= load_words[i*WORD_W + 8 +: 8];
        sh_q[2 + i*WORD_BYTES] <= load_words[i*WORD_W +: 8];
      end
    end else if (valid_q && out_ready) begin
      if (at_last) valid_q <= 1'b0;
      else         idx_q   <= idx_q + IDX_W'(1);
    end
  end

  assign out_valid = valid_q;
  assign out_data  = sh_q[idx_q];
  assign out_last  = valid_q && at_last;
  assign done      = valid_q && out_ready && at_last;
endmodule

// File: rtl/fan_cmd_handler.sv
module fan_cmd_handler
  import fan_cmd_pkg::*;
#(
  parameter int NUM_FANS = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [7:0]                 in_data,
  input  logic                       in_sof,
  input  logic                       in_eof,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [7:0]                 out_data,
  output logic                       out_last,
  input  logic [NUM_FANS-1:0]        rpm_present,
  input  logic [NUM_FANS-1:0]        pwm_present,
  input  logic [NUM_FANS*WORD_W-1:0] rpm_meas,
  input  logic [NUM_FANS*WORD_W-1:0] pwm_meas,
  output logic [NUM_FANS*WORD_W-1:0] rpm_setpt,
  output logic [NUM_FANS*WORD_W-1:0] pwm_setpt
);
  localparam int NUM_BANKS = 2;

  logic                       req_valid;
  req_kind_e                  req_kind;
  logic                       req_bank;
  logic                       req_meas;
  logic [NUM_FANS-1:0]        req_mask;
  logic [NUM_FANS*WORD_W-1:0] req_words;
  logic                       reply_done;
  logic [NUM_FANS*WORD_W-1:0] bank_setpt [NUM_BANKS];
  logic [NUM_FANS*WORD_W-1:0] src_words;
  logic [7:0]                 src_mask;

  fan_cmd_parser #(.NUM_FANS(NUM_FANS)) u_parser (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .reply_done (reply_done),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_bank   (req_bank),
    .req_meas   (req_meas),
    .req_mask   (req_mask),
    .req_words  (req_words)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    fan_cmd_bank #(.NUM_FANS(NUM_FANS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (req_valid && (req_kind == REQ_SET) && (req_bank == 1'(b))),
      .wr_mask  (req_mask),
      .wr_words (req_words),
      .setpt    (bank_setpt[b])
    );
  end

  assign rpm_setpt = bank_setpt[0];
  assign pwm_setpt = bank_setpt[1];

  always_comb begin
    if (req_bank) begin
      src_words = req_meas ? pwm_meas : bank_setpt[1];
      src_mask  = 8'(pwm_present);
    end else begin
      src_words = req_meas ? rpm_meas : bank_setpt[0];
      src_mask  = 8'(rpm_present);
    end
  end

  fan_cmd_reply #(.NUM_FANS(NUM_FANS)) u_reply (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (req_valid),
    .load_kind  (req_kind),
    .load_mask  (src_mask),
    .load_words (src_words),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .done       (reply_done)
  );
endmodule

// File: rtl/fan_cmd_handler_chk.sv
module fan_cmd_handler_chk
  import fan_cmd_pkg::*;
#(
  parameter int NUM_FANS = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_ready,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [7:0]                 out_data,
  input logic                       out_last,
  input logic [NUM_FANS*WORD_W-1:0] rpm_setpt,
  input logic [NUM_FANS*WORD_W-1:0] pwm_setpt
);
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R8
  in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R4
  rpm_write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rpm_setpt) |-> $rose(out_valid) && out_data == REPLY_ACK && out_last);

  // R4
  pwm_write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwm_setpt) |-> $rose(out_valid) && out_data == REPLY_ACK && out_last);

  // R10
  last_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

bind fan_cmd_handler fan_cmd_handler_chk #(.NUM_FANS(NUM_FANS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .rpm_setpt (rpm_setpt),
  .pwm_setpt (pwm_setpt)
);

// File: tb/fan_cmd_handler_bench.sv
module fan_cmd_handler_bench;
  localparam int NF = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = '0;
  logic          in_sof = 1'b0;
  logic          in_eof = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [7:0]    out_data;
  logic          out_last;
  logic [NF-1:0] rpm_present = 6'h2D;
  logic [NF-1:0] pwm_present = 6'h3F;
  logic [NF*16-1:0] rpm_meas;
  logic [NF*16-1:0] pwm_meas;
  logic [NF*16-1:0] rpm_setpt;
  logic [NF*16-1:0] pwm_setpt;

  int vectors = 0;
  int errors  = 0;
  logic [7:0]  fr [16];
  logic [7:0]  rep [16];
  int          rep_n;
  logic        rep_last_ok;
  logic [15:0] ew [NF];
  logic [15:0] exp_rpm [NF];
  logic [15:0] exp_pwm [NF];

  always #2.5 clk = ~clk;

  fan_cmd_handler #(.NUM_FANS(NF)) u_fan_cmd_handler (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .rpm_present(rpm_present), .pwm_present(pwm_present),
    .rpm_meas(rpm_meas), .pwm_meas(pwm_meas),
    .rpm_setpt(rpm_setpt), .pwm_setpt(pwm_setpt)
  );

  initial begin
    for (int i = 0; i < NF; i++) begin
      rpm_meas[i*16 +: 16] = 16'h3000 + 16'(i) * 16'h0101;
      pwm_meas[i*16 +: 16] = 16'h0040 + 16'(i);
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic s, input logic e);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) push(fr[i], i == 0, i == n - 1);
  endtask

  task automatic get_reply(input logic stall);
    int cyc;
    rep_n = 0; rep_last_ok = 1'b1; cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = stall ? cyc[0] : 1'b1;
      if (out_valid && out_ready) begin
        if (rep_n < 16) rep[rep_n] = out_data;
        rep_n++;
        if (out_last) break;
      end
      if (cyc > 200) begin
        chk(1'b0, "R10", "reply timeout", 32'(rep_n), 32'd1);
        break;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic chk_short(input string req, input logic [7:0] code);
    chk(rep_n == 1, "R10", "reply length", 32'(rep_n), 32'd1);
    chk(rep[0] == code, req, "status byte", 32'(rep[0]), 32'(code));
  endtask

  task automatic chk_query(input string req, input logic [7:0] mask);
    chk(rep_n == 13, "R2", "query reply length", 32'(rep_n), 32'd13);
    chk(rep[0] == mask, "R2", "active mask byte", 32'(rep[0]), 32'(mask));
    for (int i = 0; i < NF; i++)
      chk({rep[1+2*i], rep[2+2*i]} == ew[i], req, $sformatf("word fan %0d", i),
          32'({rep[1+2*i], rep[2+2*i]}), 32'(ew[i]));
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NF; i++) begin
      chk(rpm_setpt[i*16 +: 16] == exp_rpm[i], req, $sformatf("rpm setpoint %0d", i),
          32'(rpm_setpt[i*16 +: 16]), 32'(exp_rpm[i]));
      chk(pwm_setpt[i*16 +: 16] == exp_pwm[i], req, $sformatf("pwm setpoint %0d", i),
          32'(pwm_setpt[i*16 +: 16]), 32'(exp_pwm[i]));
    end
  endtask

  task automatic fill_set(input logic [7:0] code, input logic [7:0] bank,
                          input logic [7:0] mask, input logic [15:0] base);
    fr[0] = code; fr[1] = bank; fr[2] = mask;
    for (int i = 0; i < NF; i++) begin
      fr[3+2*i] = 8'((base + 16'(i) * 16'h0111) >> 8);
      fr[4+2*i] = 8'(base + 16'(i) * 16'h0111);
    end
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R7", "in_ready after reset", 32'(in_ready), 32'd1);
    chk(out_valid == 1'b0, "R7", "out_valid after reset", 32'(out_valid), 32'd0);
    for (int i = 0; i < NF; i++) begin exp_rpm[i] = '0; exp_pwm[i] = '0; end
    chk_regs("R7");
  endtask

  task automatic t_set_rpm();
    fill_set(8'h4A, 8'h00, 8'h05, 16'hA000);
    send(15);
    chk(in_ready == 1'b0, "R8", "in_ready while reply pending", 32'(in_ready), 32'd0);
    get_reply(1'b0);
    chk_short("R4", 8'h00);
    exp_rpm[0] = 16'hA000; exp_rpm[2] = 16'hA222;
    chk_regs("R5");
    chk(in_ready == 1'b1, "R8", "in_ready after reply", 32'(in_ready), 32'd1);
  endtask

  task automatic t_set_pwm_high_mask();
    fill_set(8'h4A, 8'h10, 8'hC3, 16'h0B00);
    send(15);
    get_reply(1'b1);
    chk_short("R4", 8'h00);
    exp_pwm[0] = 16'h0B00; exp_pwm[1] = 16'h0C11;
    chk_regs("R5");
  endtask

  task automatic t_query(input logic [7:0] sel, input logic stall);
    fr[0] = 8'h4A; fr[1] = sel;
    send(2);
    get_reply(stall);
    for (int i = 0; i < NF; i++) begin
      case (sel)
        8'h01:   ew[i] = rpm_meas[i*16 +: 16];
        8'h02:   ew[i] = exp_rpm[i];
        8'h11:   ew[i] = pwm_meas[i*16 +: 16];
        default: ew[i] = exp_pwm[i];
      endcase
    end
    chk_query("R3", sel[4] ? 8'(pwm_present) : 8'(rpm_present));
  endtask

  task automatic t_bad_frames();
    fr[0] = 8'h4A; fr[1] = 8'h02; fr[2] = 8'h00;
    send(3);
    get_reply(1'b0);
    chk_short("R6", 8'hFF);
    fr[0] = 8'h4A; fr[1] = 8'h03;
    send(2);
    get_reply(1'b0);
    chk_short("R6", 8'hFF);
    fill_set(8'h4A, 8'h20, 8'h3F, 16'h5555);
    send(15);
    get_reply(1'b0);
    chk_short("R6", 8'hFF);
    fr[0] = 8'h4A;
    send(1);
    get_reply(1'b0);
    chk_short("R6", 8'hFF);
    chk_regs("R6");
  endtask

  task automatic t_bad_code();
    fill_set(8'h4B, 8'h00, 8'h3F, 16'h7777);
    send(15);
    get_reply(1'b0);
    chk_short("R1", 8'hFF);
    chk_regs("R1");
  endtask

  task automatic t_stray_and_restart();
    logic seen;
    seen = 1'b0;
    push(8'h4A, 1'b0, 1'b0);
    push(8'h01, 1'b0, 1'b1);
    repeat (6) begin
      @(negedge clk);
      if (out_valid) seen = 1'b1;
    end
    chk(seen == 1'b0, "R9", "reply to stray bytes", 32'(seen), 32'd0);
    chk(in_ready == 1'b1, "R9", "in_ready after stray bytes", 32'(in_ready), 32'd1);
    push(8'h4A, 1'b1, 1'b0);
    push(8'h00, 1'b0, 1'b0);
    push(8'h3F, 1'b0, 1'b0);
    push(8'h4A, 1'b1, 1'b0);
    push(8'h02, 1'b0, 1'b1);
    get_reply(1'b0);
    for (int i = 0; i < NF; i++) ew[i] = exp_rpm[i];
    chk(rep_n == 13, "R9", "restarted frame reply length", 32'(rep_n), 32'd13);
    chk_query("R9", 8'(rpm_present));
    chk_regs("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_rpm();
    t_query(8'h02, 1'b1);
    t_set_pwm_high_mask();
    t_query(8'h12, 1'b0);
    t_query(8'h01, 1'b0);
    t_query(8'h11, 1'b1);
    t_bad_frames();
    t_bad_code();
    t_stray_and_restart();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule